// File: doc/BRIEF.md
# Top-Level Interrupt and Nesting Tracker

This block owns the highest-priority interrupt request path of a small microcontroller and keeps a record of which interrupt levels are currently pre-empted. The top-level request can come from either the watchdog end-of-count pulse or an asynchronous NMI input. The NMI input is synchronised, and its active edge can be chosen. A detected event sets a pending flag that an acknowledge pulse clears. The top-level request then goes out either gated by the global and top-level enables, or unconditionally once software has set a lock bit. Software can set that lock bit, but only reset clears it.

The same control register also picks what drives the lowest external interrupt channel: the external pin or the watchdog. It holds the upper nibble of the external vector and a wait-pin enable. A second register shows the lock bit beside a seven-bit hold record. Hardware sets one bit of the hold record when the routine at that level is pre-empted in nested mode by a request that is not the top-level one. Hardware clears that bit on the interrupt-return strobe that names the level.

Top module: `tl_irq_nest`

## Requirements
- R1: After reset, the control register (address 0) reads 0110 in bits 3:0. In those bits, bit 3 selects the edge, bit 2 the top-level source, bit 1 the channel-0 source and bit 0 the wait enable. The nesting register (address 1) reads 0x00, and tl_pend_o, tl_req_o and wait_en_o are all 0.
- R2: Bits 7:4 of the control register hold the last value written to them. Reset leaves them unchanged.
- R3: With top-level source bit 2 = 1, an NMI edge sets the pending flag within four clock edges. Bit 3 = 1 selects the rising edge and bit 3 = 0 the falling edge. The other edge has no effect.
- R4: With bit 2 = 0, a watchdog pulse sets the pending flag at the next clock edge and NMI edges are ignored. With bit 2 = 1, watchdog pulses do not set it.
- R5: The pending flag stays set until tl_ack_i is high at a clock edge. If a new event arrives in the same cycle as the acknowledge, the flag stays set.
- R6: With the lock bit at 0, tl_req_o is high only when glob_en_i, tl_en_i and the pending flag are all 1.
- R7: Writing 1 to bit 7 of the nesting register sets the lock bit. Writing 0 to it is ignored, and only reset clears it. While the lock bit is set, tl_req_o follows the pending flag whatever the enables are.
- R8: a0_req_o follows ext_pin_i when bit 1 = 1. When bit 1 = 0 it follows wdog_eoc_i, but only if bit 2 = 1. When bits 2 and 1 are both 0 it is held at 0, so the watchdog drives only one path.
- R9: Bit 0 of the control register reads back as written and drives wait_en_o.
- R10: Hold bit x (nesting register bit x, x = 0..6) is set when preempt_i is high with nest_mode_i = 1, preempt_top_i = 0 and cur_lvl_i = x. Pre-emptions that are top-level, that occur outside nested mode, or that carry level 7 change nothing.
- R11: iret_i clears hold bit iret_lvl_i at the strobe's clock edge. If a pre-emption and a return name the same level in the same cycle, the return wins.
- R12: Software writes to bits 6:0 of the nesting register do not change the hold record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = control register, 1 = nesting register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the addressed register (combinational) |
| wdog_eoc_i | input | 1 | Watchdog end-of-count pulse, synchronous |
| nmi_i | input | 1 | Asynchronous non-maskable interrupt input |
| ext_pin_i | input | 1 | External interrupt pin for channel 0, synchronous |
| glob_en_i | input | 1 | Global interrupt enable |
| tl_en_i | input | 1 | Top-level interrupt enable |
| tl_ack_i | input | 1 | Acknowledge, clears the pending flag |
| nest_mode_i | input | 1 | Nested mode active |
| preempt_i | input | 1 | Running routine is being pre-empted |
| preempt_top_i | input | 1 | The pre-empting request is the top-level one |
| cur_lvl_i | input | 3 | Level of the routine being pre-empted |
| iret_i | input | 1 | Interrupt-return strobe |
| iret_lvl_i | input | 3 | Level resumed by the return |
| tl_pend_o | output | 1 | Top-level pending flag |
| tl_req_o | output | 1 | Top-level request |
| a0_req_o | output | 1 | Channel-0 interrupt source |
| wait_en_o | output | 1 | Wait-pin enable |

## Verification
The assertions assume that wdog_eoc_i, ext_pin_i, the strobes and the level buses are synchronous to clk_i. They also assume that preempt_i and iret_i are one-cycle pulses carrying a stable level. The bench drives every input at the falling edge, so nothing changes near the active edge. It holds each NMI level for at least four cycles, so an edge always passes the synchroniser before the next one arrives. It raises a pre-emption and a return together only in the cases where it deliberately checks coincident strobes.

// File: rtl/tl_irq_pkg.sv
package tl_irq_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned NUM_LVL = REG_W - 1;
  localparam int unsigned LVL_W   = $clog2(NUM_LVL + 1);
  localparam logic [3:0]  CTRL_LO_RST = 4'b0110;

  typedef struct packed {
    logic [3:0] vec_hi;
    logic       trig_rise;
    logic       tl_sel_nmi;
    logic       a0_sel_pin;
    logic       wait_en;
  } ctrl_t;
endpackage

// File: rtl/tl_ctrl_regs.sv
module tl_ctrl_regs
  import tl_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic [NUM_LVL-1:0] hold_i,
  output logic [REG_W-1:0]   rdata_o,
  output ctrl_t              ctrl_o,
  output logic               lock_o
);
  logic [3:0] vec_hi_q;
  logic [3:0] ctrl_lo_q;
  logic       lock_q;
  logic       wr_ctrl, wr_nest;

  assign wr_ctrl = we_i && !addr_i;
  assign wr_nest = we_i && addr_i;

  // vector nibble deliberately has no reset
  always_ff @(posedge clk_i) begin
    if (wr_ctrl) vec_hi_q <= wdata_i[7:4];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_lo_q <= CTRL_LO_RST;
    else if (wr_ctrl) ctrl_lo_q <= wdata_i[3:0];
  end

  // sticky: only reset clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         lock_q <= 1'b0;
    else if (wr_nest && wdata_i[REG_W-1]) lock_q <= 1'b1;
  end

  assign ctrl_o  = ctrl_t'({vec_hi_q, ctrl_lo_q});
  assign lock_o  = lock_q;
  assign rdata_o = addr_i ? {lock_q, hold_i} : {vec_hi_q, ctrl_lo_q};

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q); // R7
  AST_LOCK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_nest && wdata_i[REG_W-1]) |=> lock_o); // R7
  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (ctrl_o.wait_en == $past(wdata_i[0]))); // R9
endmodule

// File: rtl/tl_src_path.sv
module tl_src_path #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic wdog_i,
  input  logic ext_pin_i,
  input  logic trig_rise_i,
  input  logic sel_nmi_i,
  input  logic a0_pin_i,
  input  logic ack_i,
  input  logic glob_en_i,
  input  logic tl_en_i,
  input  logic lock_i,
  output logic pend_o,
  output logic tl_req_o,
  output logic a0_req_o
);
  logic nmi_s, nmi_d, nmi_edge, tl_evt, pend_q;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], nmi_i};
      end
      assign nmi_s = sync_q[SYNC_STAGES-1];
    end else begin : g_sync_single
      logic sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 1'b0;
        else         sync_q <= nmi_i;
      end
      assign nmi_s = sync_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nmi_d <= 1'b0;
    else         nmi_d <= nmi_s;
  end

  assign nmi_edge = trig_rise_i ? (nmi_s && !nmi_d) : (!nmi_s && nmi_d);
  assign tl_evt   = sel_nmi_i ? nmi_edge : wdog_i;

  // new event beats acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (tl_evt) pend_q <= 1'b1;
    else if (ack_i)  pend_q <= 1'b0;
  end

  assign pend_o   = pend_q;
  assign tl_req_o = pend_q && (lock_i || (glob_en_i && tl_en_i));
  // watchdog feeds channel 0 only when top level has released it
  assign a0_req_o = a0_pin_i ? ext_pin_i : (sel_nmi_i && wdog_i);

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ack_i) |=> pend_q); // R5
  AST_ACK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !tl_evt) |=> !pend_o); // R5
  AST_WDOG_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_nmi_i && wdog_i) |=> pend_o); // R4
  AST_LOCK_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && pend_o) |-> tl_req_o); // R7
  AST_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_i && !(glob_en_i && tl_en_i)) |-> !tl_req_o); // R6
  AST_A0_NO_WDOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_nmi_i && !a0_pin_i) |-> !a0_req_o); // R8
endmodule

// File: rtl/tl_hold_track.sv
module tl_hold_track
  import tl_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               nest_mode_i,
  input  logic               preempt_i,
  input  logic               preempt_top_i,
  input  logic [LVL_W-1:0]   cur_lvl_i,
  input  logic               iret_i,
  input  logic [LVL_W-1:0]   iret_lvl_i,
  output logic [NUM_LVL-1:0] hold_o
);
  logic [NUM_LVL-1:0] hold_q;
  logic               do_set;

  assign do_set = nest_mode_i && preempt_i && !preempt_top_i;

  generate
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
      logic set_g, clr_g;
      assign set_g = do_set && (cur_lvl_i == LVL_W'(g));
      assign clr_g = iret_i && (iret_lvl_i == LVL_W'(g));
      // return wins on the same level
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    hold_q[g] <= 1'b0;
        else if (clr_g) hold_q[g] <= 1'b0;
        else if (set_g) hold_q[g] <= 1'b1;
      end
    end
  endgenerate

  assign hold_o = hold_q;

  AST_HOLD_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_set && (cur_lvl_i < LVL_W'(NUM_LVL)) && !(iret_i && iret_lvl_i == cur_lvl_i))
    |=> hold_o[$past(cur_lvl_i)]); // R10
  AST_HOLD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iret_i && (iret_lvl_i < LVL_W'(NUM_LVL))) |=> !hold_o[$past(iret_lvl_i)]); // R11
  AST_NO_SPUR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !do_set |=> ((hold_o & ~$past(hold_o)) == '0)); // R10
endmodule

// File: rtl/tl_irq_nest.sv
module tl_irq_nest
  import tl_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             wdog_eoc_i,
  input  logic             nmi_i,
  input  logic             ext_pin_i,
  input  logic             glob_en_i,
  input  logic             tl_en_i,
  input  logic             tl_ack_i,
  input  logic             nest_mode_i,
  input  logic             preempt_i,
  input  logic             preempt_top_i,
  input  logic [LVL_W-1:0] cur_lvl_i,
  input  logic             iret_i,
  input  logic [LVL_W-1:0] iret_lvl_i,
  output logic             tl_pend_o,
  output logic             tl_req_o,
  output logic             a0_req_o,
  output logic             wait_en_o
);
  ctrl_t              ctrl;
  logic               lock;
  logic [NUM_LVL-1:0] hold;

  tl_ctrl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .hold_i  (hold),
    .rdata_o (reg_rdata_o),
    .ctrl_o  (ctrl),
    .lock_o  (lock)
  );

  tl_src_path #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nmi_i       (nmi_i),
    .wdog_i      (wdog_eoc_i),
    .ext_pin_i   (ext_pin_i),
    .trig_rise_i (ctrl.trig_rise),
    .sel_nmi_i   (ctrl.tl_sel_nmi),
    .a0_pin_i    (ctrl.a0_sel_pin),
    .ack_i       (tl_ack_i),
    .glob_en_i   (glob_en_i),
    .tl_en_i     (tl_en_i),
    .lock_i      (lock),
    .pend_o      (tl_pend_o),
    .tl_req_o    (tl_req_o),
    .a0_req_o    (a0_req_o)
  );

  tl_hold_track u_hold (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .nest_mode_i   (nest_mode_i),
    .preempt_i     (preempt_i),
    .preempt_top_i (preempt_top_i),
    .cur_lvl_i     (cur_lvl_i),
    .iret_i        (iret_i),
    .iret_lvl_i    (iret_lvl_i),
    .hold_o        (hold)
  );

  assign wait_en_o = ctrl.wait_en;
endmodule

// File: tb/tl_irq_nest_tb_top.sv
module tl_irq_nest_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       wdog = 1'b0, nmi = 1'b0, ext = 1'b0;
  logic       glob = 1'b0, tlen = 1'b0, ack = 1'b0;
  logic       nest = 1'b0, pre = 1'b0, pre_top = 1'b0, iret = 1'b0;
  logic [2:0] lvl = '0, ilvl = '0;
  logic       pend, req, a0, wen;
  int checks = 0, errs = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  tl_irq_nest dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .wdog_eoc_i(wdog), .nmi_i(nmi),
    .ext_pin_i(ext), .glob_en_i(glob), .tl_en_i(tlen), .tl_ack_i(ack),
    .nest_mode_i(nest), .preempt_i(pre), .preempt_top_i(pre_top), .cur_lvl_i(lvl),
    .iret_i(iret), .iret_lvl_i(ilvl), .tl_pend_o(pend), .tl_req_o(req),
    .a0_req_o(a0), .wait_en_o(wen)
  );

  // {tl_sel_nmi, a0_sel_pin, wdog, ext, expected a0}
  localparam logic [4:0] A0_TAB [8] = '{
    5'b11011, 5'b11100, 5'b10101, 5'b10010,
    5'b01100, 5'b01011, 5'b00110, 5'b00000
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a; #2; d = rdata;
  endtask

  task automatic do_ack();
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  task automatic preempt(input logic n, input logic t, input logic [2:0] l);
    nest = n; pre_top = t; lvl = l; pre = 1'b1; cyc(1); pre = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    checks++; errs++;
    $display("FAIL all requirements: watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    cyc(3); rst_ni = 1'b1; cyc(1);
    // R1 reset state
    rd(1'b0, rv); chk("R1 ctrl low", rv & 8'h0F, 8'h06);
    rd(1'b1, rv); chk("R1 nest reg", rv, 8'h00);
    chk("R1 pend", {7'd0, pend}, 8'd0);
    chk("R1 req", {7'd0, req}, 8'd0);
    chk("R1 wait_en", {7'd0, wen}, 8'd0);
    glob = 1'b1; tlen = 1'b1;

    // R8 channel-0 source table
    for (int i = 0; i < 8; i++) begin
      wr(1'b0, 8'hA0 | {5'd0, A0_TAB[i][4], A0_TAB[i][3], 1'b0});
      wdog = A0_TAB[i][2]; ext = A0_TAB[i][1]; #2;
      chk($sformatf("R8 row %0d", i), {7'd0, a0}, {7'd0, A0_TAB[i][0]});
    end
    wdog = 1'b0; ext = 1'b0; cyc(1); do_ack();
    chk("R5 ack clears", {7'd0, pend}, 8'd0);

    // R3 edge select, rising
    wr(1'b0, 8'hAE);
    nmi = 1'b1; cyc(4);
    chk("R3 rising sets", {7'd0, pend}, 8'd1);
    chk("R6 req all enabled", {7'd0, req}, 8'd1);
    cyc(3);
    chk("R5 pend held", {7'd0, pend}, 8'd1);
    do_ack();
    chk("R5 ack", {7'd0, pend}, 8'd0);
    nmi = 1'b0; cyc(4);
    chk("R3 falling ignored", {7'd0, pend}, 8'd0);
    // falling
    wr(1'b0, 8'hA6);
    nmi = 1'b1; cyc(4);
    chk("R3 rising ignored", {7'd0, pend}, 8'd0);
    nmi = 1'b0; cyc(4);
    chk("R3 falling sets", {7'd0, pend}, 8'd1);
    do_ack();

    // R4 source select
    wdog = 1'b1; cyc(1); wdog = 1'b0; cyc(1);
    chk("R4 wdog ignored with NMI source", {7'd0, pend}, 8'd0);
    wr(1'b0, 8'hA2);
    wdog = 1'b1; cyc(1); wdog = 1'b0;
    chk("R4 wdog sets", {7'd0, pend}, 8'd1);
    do_ack();
    nmi = 1'b1; cyc(4); nmi = 1'b0; cyc(4);
    chk("R4 NMI ignored", {7'd0, pend}, 8'd0);

    // R5 event with ack
    wdog = 1'b1; cyc(1); wdog = 1'b0;
    wdog = 1'b1; ack = 1'b1; cyc(1); wdog = 1'b0; ack = 1'b0;
    chk("R5 event beats ack", {7'd0, pend}, 8'd1);

    // R6 masking
    glob = 1'b0; #2; chk("R6 glob off", {7'd0, req}, 8'd0);
    glob = 1'b1; tlen = 1'b0; #2; chk("R6 tl_en off", {7'd0, req}, 8'd0);
    tlen = 1'b1; #2; chk("R6 both on", {7'd0, req}, 8'd1);

    // R7 lock
    glob = 1'b0;
    wr(1'b1, 8'h80);
    chk("R7 lock forces req", {7'd0, req}, 8'd1);
    rd(1'b1, rv); chk("R7 lock read", rv, 8'h80);
    wr(1'b1, 8'h00);
    rd(1'b1, rv); chk("R7 zero write ignored", rv, 8'h80);
    do_ack();
    chk("R7 req follows pend", {7'd0, req}, 8'd0);

    // R9 wait enable
    wr(1'b0, 8'hA3);
    chk("R9 wait_en", {7'd0, wen}, 8'd1);
    rd(1'b0, rv); chk("R9 readback", rv, 8'hA3);

    // R10 hold set
    preempt(1'b1, 1'b0, 3'd3);
    rd(1'b1, rv); chk("R10 level 3", rv, 8'h88);
    preempt(1'b1, 1'b1, 3'd5);
    rd(1'b1, rv); chk("R10 top ignored", rv, 8'h88);
    preempt(1'b0, 1'b0, 3'd1);
    rd(1'b1, rv); chk("R10 non-nested ignored", rv, 8'h88);
    preempt(1'b1, 1'b0, 3'd7);
    rd(1'b1, rv); chk("R10 level 7 ignored", rv, 8'h88);
    preempt(1'b1, 1'b0, 3'd0);
    rd(1'b1, rv); chk("R10 level 0", rv, 8'h89);

    // R12 software cannot touch hold bits
    wr(1'b1, 8'h7F);
    rd(1'b1, rv); chk("R12 hold write ignored", rv, 8'h89);

    // R11 return clears
    ilvl = 3'd3; iret = 1'b1; cyc(1); iret = 1'b0;
    rd(1'b1, rv); chk("R11 iret level 3", rv, 8'h81);
    ilvl = 3'd0; iret = 1'b1; lvl = 3'd0; pre = 1'b1; cyc(1); iret = 1'b0; pre = 1'b0;
    rd(1'b1, rv); chk("R11 iret wins", rv, 8'h80);
    ilvl = 3'd0; iret = 1'b1; lvl = 3'd2; pre = 1'b1; cyc(1); iret = 1'b0; pre = 1'b0;
    rd(1'b1, rv); chk("R11 distinct levels", rv, 8'h84);

    // R2 vector nibble survives reset, R7 lock cleared by reset
    wr(1'b0, 8'h53);
    rst_ni = 1'b0; cyc(2); rst_ni = 1'b1; cyc(1);
    rd(1'b0, rv); chk("R2 vector kept", rv, 8'h56);
    rd(1'b1, rv); chk("R7 reset clears lock", rv, 8'h00);
    chk("R1 wait_en after reset", {7'd0, wen}, 8'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule